// File: doc/BRIEF.md
# Line-State Bit Signaling Engine

This block trades a short vector of bits with the link partner at the far end of a serial line. Each bit goes out as a line state held for one bit slot: a one is held as Halt and a zero as Master. During the same slot the engine takes the line state arriving from the partner as the partner's bit. One exchange carries from 1 to 16 bits. The bit period comes from outside as a single-cycle strobe, so the timers that set the slot length are not part of this block.

A host programs the bit count, then writes the transmit vector, and that write starts the exchange. While an exchange is running, the transmit vector and the count cannot change. A host write to either one is dropped and raises a sticky error flag. When the last slot has been sampled, the busy flag clears, a one-cycle done pulse is raised, and the line request goes back to idle. The host then reads the received vector. A received line state that is neither Halt nor Master is taken as a zero and raises a second sticky flag.

Top module: `lsbit_signal_engine`

## Requirements
- R1: Transmit bit 0 goes out in the first slot, bit 1 in the second, and so on. After (count field + 1) sampled slots the exchange ends, and later vector bits are never sent.
- R2: The count register (address 1) keeps only write bits 3:0, which hold the bit count minus one. Read bits 15:4 are always zero.
- R3: The line request `tx_ls` is 2'b01 (Halt) for a one bit and 2'b10 (Master) for a zero bit while busy. It is 2'b00 (idle) whenever the engine is not busy.
- R4: A write to the transmit vector (address 0) while not busy stores the vector and sets `busy` from the next cycle. Each `bit_tick` while busy ends the current slot.
- R5: While busy, a write to address 0 or address 1 leaves both registers unchanged and sets `wr_err`.
- R6: On the `bit_tick` that ends slot n, receive bit n becomes 1 if `rx_ls` is 2'b01 (Halt) and 0 if it is 2'b10 (Master). The receive vector is read at address 2.
- R7: The edge that samples the final slot clears `busy` and raises `done` for exactly one cycle.
- R8: Reset clears the transmit vector, the count, the receive vector, `busy`, `done`, `wr_err` and `bad_sig`.
- R9: `wr_err` stays set until a write to the status register (address 3) with data bit 1 set. Status reads return busy in bit 0, wr_err in bit 1 and bad_sig in bit 2.
- R10: A sampled `rx_ls` of 2'b00 or 2'b11 stores a 0 in the receive bit and sets sticky `bad_sig`. A status write with data bit 2 set clears `bad_sig`.
- R11: Starting an exchange clears the whole receive vector, so a read during the exchange shows zeros in the slots not yet sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 2 | Host write address (0 transmit, 1 count, 3 status) |
| wr_data | input | 16 | Host write data |
| rd_addr | input | 2 | Host read address (0 transmit, 1 count, 2 receive, 3 status) |
| rd_data | output | 16 | Host read data, combinational from registers |
| bit_tick | input | 1 | Single-cycle strobe that ends the current bit slot |
| rx_ls | input | 2 | Decoded received line state (00 idle, 01 Halt, 10 Master, 11 quiet) |
| tx_ls | output | 2 | Requested transmit line state, same encoding |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse after the final slot is sampled |
| wr_err | output | 1 | Sticky flag: write refused while busy |
| bad_sig | output | 1 | Sticky flag: a sampled line state was neither Halt nor Master |

## Verification
The hardest case to reach from the ports is a host write that collides with a running exchange. The collision has to fall between two strobes, and afterwards the stored count and vector must be shown to be unchanged. The bench therefore stops its strobe driver after the first slot, issues both refused writes, and reads the registers back through the host port. Only then does it resume the slots, and it checks that the line request still follows the original vector. The full 16-bit exchange and the single-bit exchange with a quiet line are driven to cover both ends of the count field.

// File: rtl/lsb_pkg.sv
package lsb_pkg;

    typedef enum logic [1:0] {
        LS_IDLE   = 2'b00,
        LS_HALT   = 2'b01,
        LS_MASTER = 2'b10,
        LS_QUIET  = 2'b11
    } line_state_e;

    typedef enum logic [1:0] {
        A_TXV  = 2'd0,
        A_LEN  = 2'd1,
        A_RXV  = 2'd2,
        A_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic bad_sig;
        logic wr_err;
        logic busy;
    } status_t;

    typedef struct packed {
        logic valid;
        logic value;
    } rx_bit_t;

    localparam int STAT_ERR_BIT = 1;
    localparam int STAT_BAD_BIT = 2;

    function automatic line_state_e encode_bit(input logic b);
        return b ? LS_HALT : LS_MASTER;
    endfunction

    function automatic rx_bit_t decode_state(input logic [1:0] ls);
        rx_bit_t r;
        r.valid = (ls == LS_HALT) || (ls == LS_MASTER);
        r.value = (ls == LS_HALT);
        return r;
    endfunction

endpackage

// File: rtl/lsb_host_regs.sv
module lsb_host_regs
    import lsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 16,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic [VEC_W-1:0]  tx_vec,
    output logic [LEN_W-1:0]  len,
    output logic              start,
    output logic              wr_err,
    output logic              clr_bad
);

    logic hit_tx, hit_len, hit_stat, refused, clr_err;

    always_comb begin
        hit_tx   = wr_en && (wr_addr == A_TXV);
        hit_len  = wr_en && (wr_addr == A_LEN);
        hit_stat = wr_en && (wr_addr == A_STAT);
        refused  = busy && (hit_tx || hit_len);
        start    = hit_tx && !busy;
        clr_err  = hit_stat && wr_data[STAT_ERR_BIT];
        clr_bad  = hit_stat && wr_data[STAT_BAD_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_vec <= '0;
            len    <= '0;
            wr_err <= 1'b0;
        end else begin
            if (hit_tx && !busy)
                tx_vec <= wr_data[VEC_W-1:0];
            if (hit_len && !busy)
                len <= wr_data[LEN_W-1:0];
            if (refused)
                wr_err <= 1'b1;
            else if (clr_err)
                wr_err <= 1'b0;
        end
    end

endmodule

// File: rtl/lsb_sequencer.sv
module lsb_sequencer
    import lsb_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             bit_tick,
    input  logic [LEN_W-1:0] len,
    input  logic [VEC_W-1:0] tx_vec,
    output logic             busy,
    output logic             done,
    output logic [LEN_W-1:0] idx,
    output logic             sample,
    output logic [1:0]       tx_ls
);

    line_state_e ls_req;

    always_comb begin
        sample = busy && bit_tick;
        ls_req = busy ? encode_bit(tx_vec[idx]) : LS_IDLE;
        tx_ls  = ls_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                idx  <= '0;
            end else if (sample) begin
                if (idx == len) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    idx  <= '0;
                end else begin
                    idx <= idx + LEN_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/lsb_capture.sv
module lsb_capture
    import lsb_pkg::*;
#(
    parameter int VEC_W = 16,
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             sample,
    input  logic [LEN_W-1:0] idx,
    input  logic [1:0]       rx_ls,
    input  logic             clr_bad,
    output logic [VEC_W-1:0] rx_vec,
    output logic             bad_sig
);

    rx_bit_t cur;

    always_comb cur = decode_state(rx_ls);

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_vec  <= '0;
            bad_sig <= 1'b0;
        end else begin
            if (start)
                rx_vec <= '0;
            else if (sample)
                rx_vec[idx] <= cur.valid && cur.value;
            if (sample && !cur.valid)
                bad_sig <= 1'b1;
            else if (clr_bad)
                bad_sig <= 1'b0;
        end
    end

endmodule

// File: rtl/lsbit_signal_engine.sv
module lsbit_signal_engine
    import lsb_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 16,
    parameter int LEN_W  = $clog2(VEC_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              bit_tick,
    input  logic [1:0]        rx_ls,
    output logic [1:0]        tx_ls,
    output logic              busy,
    output logic              done,
    output logic              wr_err,
    output logic              bad_sig
);

    localparam int STAT_W = $bits(status_t);

    logic [VEC_W-1:0] tx_vec_q, rx_vec_q;
    logic [LEN_W-1:0] len_q, idx_q;
    logic             start, sample, clr_bad;
    status_t          stat;

    lsb_host_regs #(.DATA_W(DATA_W), .VEC_W(VEC_W), .LEN_W(LEN_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .busy    (busy),
        .tx_vec  (tx_vec_q),
        .len     (len_q),
        .start   (start),
        .wr_err  (wr_err),
        .clr_bad (clr_bad)
    );

    lsb_sequencer #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .bit_tick (bit_tick),
        .len      (len_q),
        .tx_vec   (tx_vec_q),
        .busy     (busy),
        .done     (done),
        .idx      (idx_q),
        .sample   (sample),
        .tx_ls    (tx_ls)
    );

    lsb_capture #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_cap (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sample  (sample),
        .idx     (idx_q),
        .rx_ls   (rx_ls),
        .clr_bad (clr_bad),
        .rx_vec  (rx_vec_q),
        .bad_sig (bad_sig)
    );

    always_comb begin
        stat.busy    = busy;
        stat.wr_err  = wr_err;
        stat.bad_sig = bad_sig;
        rd_data      = '0;
        unique case (rd_addr)
            A_TXV:   rd_data[VEC_W-1:0]  = tx_vec_q;
            A_LEN:   rd_data[LEN_W-1:0]  = len_q;
            A_RXV:   rd_data[VEC_W-1:0]  = rx_vec_q;
            default: rd_data[STAT_W-1:0] = stat;
        endcase
    end

endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
    parameter int DATA_W = 16,
    parameter int VEC_W  = 16,
    parameter int LEN_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        rd_addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [1:0]        tx_ls,
    input logic              busy,
    input logic              done,
    input logic              wr_err,
    input logic              bad_sig,
    input logic [VEC_W-1:0]  tx_q,
    input logic [LEN_W-1:0]  len_q,
    input logic [LEN_W-1:0]  idx_q
);

    a_r4_start_sets_busy: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 2'd0 && !busy) |=> busy);

    a_r5_len_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == 2'd1) |=> ($stable(len_q) && wr_err));

    a_r5_tx_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && wr_addr == 2'd0) |=> ($stable(tx_q) && wr_err));

    a_r3_idle_when_free: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (tx_ls == 2'b00));

    a_r3_signal_when_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tx_ls == 2'b01 || tx_ls == 2'b10));

    a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    a_r1_slot_in_range: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx_q <= len_q));

    a_r2_len_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == 2'd1) |-> (rd_data[DATA_W-1:LEN_W] == '0));

    a_r9_err_sticky: assert property (@(posedge clk) disable iff (rst)
        (wr_err && !(wr_en && wr_addr == 2'd3 && wr_data[1])) |=> wr_err);

    a_r10_bad_sticky: assert property (@(posedge clk) disable iff (rst)
        (bad_sig && !(wr_en && wr_addr == 2'd3 && wr_data[2])) |=> bad_sig);

endmodule

bind lsbit_signal_engine lsb_checker #(.DATA_W(DATA_W), .VEC_W(VEC_W), .LEN_W(LEN_W)) i_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .tx_ls   (tx_ls),
    .busy    (busy),
    .done    (done),
    .wr_err  (wr_err),
    .bad_sig (bad_sig),
    .tx_q    (tx_vec_q),
    .len_q   (len_q),
    .idx_q   (idx_q)
);

// File: tb/test_lsbit_signal_engine.sv
`timescale 1ns/1ps
module test_lsbit_signal_engine;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        bit_tick = 1'b0;
    logic [1:0]  rx_ls = 2'b00;
    logic [1:0]  tx_ls;
    logic        busy, done, wr_err, bad_sig;

    int n_checks = 0;
    int n_err = 0;
    logic [1:0] exp_q[$];

    always #4 clk = ~clk;

    lsbit_signal_engine i_lsbit_signal_engine (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bit_tick(bit_tick), .rx_ls(rx_ls),
        .tx_ls(tx_ls), .busy(busy), .done(done), .wr_err(wr_err), .bad_sig(bad_sig)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    endtask

    task automatic host_wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [1:0] a, output logic [15:0] d);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    // Scoreboard monitor: each slot-ending strobe pops the expected line state.
    always @(negedge clk) begin
        logic [1:0] e;
        if (!rst && bit_tick && busy) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R1 extra slot", {30'd0, tx_ls}, 32'd0);
            end else begin
                e = exp_q.pop_front();
                check(tx_ls == e, "R1/R3 line state per slot", {30'd0, tx_ls}, {30'd0, e});
            end
        end
    end

    task automatic one_slot(input logic [1:0] ls, input bit last);
        repeat (2) @(posedge clk);
        #1; rx_ls = ls; bit_tick = 1'b1;
        @(posedge clk); #1;
        bit_tick = 1'b0; rx_ls = 2'b00;
        if (last) begin
            @(negedge clk);
            check(done && !busy, "R7 done with busy low after last slot", {busy, done}, 2'b01);
            @(negedge clk);
            check(!done, "R7 done lasts one cycle", {31'd0, done}, 32'd0);
            check(tx_ls == 2'b00, "R3 idle after exchange", {30'd0, tx_ls}, 32'd0);
        end
    endtask

    // Driver: pushes expected line states, runs an exchange, checks the receive vector.
    task automatic run_vec(input logic [15:0] v, input int n, input logic [31:0] rxs, input bit poke);
        logic [15:0] exp_rx = '0;
        logic [15:0] d;
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(v[i] ? 2'b01 : 2'b10);
            exp_rx[i] = (rxs[2*i +: 2] == 2'b01);
        end
        host_wr(2'd1, 16'(n - 1));
        host_wr(2'd0, v);
        check(busy, "R4 busy after vector write", {31'd0, busy}, 32'd1);
        host_rd(2'd2, d);
        check(d == 16'h0, "R11 receive vector cleared at start", {16'd0, d}, 32'd0);
        for (int i = 0; i < n; i++) begin
            one_slot(rxs[2*i +: 2], i == n - 1);
            if (poke && i == 0) begin
                host_wr(2'd1, 16'h0003);
                host_wr(2'd0, ~v);
                host_rd(2'd1, d);
                check(d == 16'(n - 1), "R5 count unchanged while busy", {16'd0, d}, n - 1);
                host_rd(2'd0, d);
                check(d == v, "R5 vector unchanged while busy", {16'd0, d}, {16'd0, v});
                check(wr_err, "R5 wr_err set by refused write", {31'd0, wr_err}, 32'd1);
                host_rd(2'd3, d);
                check(d == 16'h0003, "R9 status shows busy and wr_err", {16'd0, d}, 32'h3);
            end
        end
        host_rd(2'd2, d);
        check(d == exp_rx, "R6 receive vector", {16'd0, d}, {16'd0, exp_rx});
        check(exp_q.size() == 0, "R1 all slots used", exp_q.size(), 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        report();
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R8: reset state
        host_rd(2'd0, d); check(d == 0, "R8 transmit vector reset", {16'd0, d}, 0);
        host_rd(2'd1, d); check(d == 0, "R8 count reset", {16'd0, d}, 0);
        host_rd(2'd2, d); check(d == 0, "R8 receive vector reset", {16'd0, d}, 0);
        host_rd(2'd3, d); check(d == 0, "R8 status reset", {16'd0, d}, 0);
        check(tx_ls == 2'b00 && !done, "R3 idle after reset", {29'd0, done, tx_ls}, 0);

        // R2: only the low four bits of the count survive
        host_wr(2'd1, 16'hFFF7);
        host_rd(2'd1, d); check(d == 16'h0007, "R2 count upper bits read zero", {16'd0, d}, 7);

        // R4 R5 R6: 8-bit exchange with refused writes after slot 0
        run_vec(16'h00A5, 8, 32'h0000_6996, 1'b1);
        host_rd(2'd3, d);
        check(d == 16'h0002, "R9 wr_err sticky after exchange", {16'd0, d}, 2);
        host_wr(2'd3, 16'h0002);
        host_rd(2'd3, d);
        check(d == 16'h0000, "R9 wr_err cleared by status write", {16'd0, d}, 0);

        // R1: full 16-bit exchange at the top of the count range
        run_vec(16'h8001, 16, 32'h6996_5A5A, 1'b0);
        check(!bad_sig && !wr_err, "R10 no flags on valid states", {30'd0, bad_sig, wr_err}, 0);

        // R10: single-bit exchange on a quiet line, then an idle line
        run_vec(16'h0001, 1, 32'h0000_0003, 1'b0);
        host_rd(2'd3, d);
        check(d == 16'h0004, "R10 bad_sig set by quiet line", {16'd0, d}, 4);
        host_wr(2'd3, 16'h0004);
        check(!bad_sig, "R10 bad_sig cleared", {31'd0, bad_sig}, 0);
        run_vec(16'h0002, 2, 32'h0000_0001, 1'b0);
        check(bad_sig, "R10 bad_sig set by idle line", {31'd0, bad_sig}, 1);
        host_rd(2'd1, d); check(d == 16'h0001, "R1 count kept after exchange", {16'd0, d}, 1);

        report();
        $finish;
    end

endmodule